// File: doc/BRIEF.md
# SCSI Controller Command Execution Engine

This block is the command-execution core of a SCSI interface controller. At a fixed interval, and again right after software writes the command register, it takes one evaluation step: it looks at the pending command bits together with the live connection and transfer status, decides which commands can be accepted, and issues one-cycle strobes that set or clear status flags and clear accepted command bits. The registers themselves live outside this block; the engine only reads their current fields and returns update strobes.

Every step also advances a 3-bit bus-phase counter kept in the transfer status register. The step reports the advanced value, and that value is the one a transfer compares against. Three commands are handled. Disconnect drops the connection. Select starts a selection. Transfer sends one byte in programmed-I/O mode when the phase fields agree and no selection is in progress. A transfer marked for DMA stays pending. The engine also holds the internal connected flag and the connected target number. A bus-side acknowledge input sets that flag and number.

Within one step the commands are applied in the order disconnect, select, transfer. The transfer test uses the selection-in-progress value that the two earlier commands leave behind.

Top module: `scsi_cmd_engine`

## Requirements
- R1: After reset, all strobes, `step_vld`, `tx_vld` and `linked` are 0, and `link_id` is 0.
- R2: With no command writes, `step_vld` pulses once every 2^TICK_LOG2 clock cycles.
- R3: On each step, `phase_nxt` equals `dstat_phase + 1` modulo 8. Strobes and `cmd_clr` are 0 in every cycle in which `step_vld` is 0.
- R4: When `cmd_wr` is sampled high at a clock edge, an evaluation step is reported on `step_vld` two edges later.
- R5: If disconnect (command bit 7) is set, the step raises `con_clr` and `cmd_clr[7]` and clears `linked`. It raises `sip_clr` unless select is also set. It raises `sch_set` only if `linked` was 1 before the step.
- R6: If select (command bit 6) is set, the step raises `sip_set` and `cmd_clr[6]`, and afterwards `linked` is 0 and `link_id` is 0.
- R7: A transfer (command bit 5) qualifies only when command bits [4:2] equal `cstat_phase`, command bits [1:0] equal `phase_nxt[1:0]` (the advanced count), and selection-in-progress is clear after disconnect and select have been applied.
- R8: A qualified transfer with DMA (command bit 8) clear raises `tbe_set`, `cmd_clr[5]` and a one-cycle `tx_vld`, with `tx_byte` equal to `data_byte`.
- R9: A qualified transfer with DMA set produces no `tbe_set`, no `tx_vld`, and leaves `cmd_clr[5]` at 0.
- R10: Ordering: select in the same step blocks a transfer. Disconnect in the same step, with `cstat_sip` 1, lets a matching transfer proceed.
- R11: A `link_ack` pulse sets `linked` to 1 and loads `link_id` from `link_ack_id` on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Command register was written this cycle |
| cmd_word | input | 9 | Command register: [1:0] data phase, [4:2] bus phase, 5 transfer, 6 select, 7 disconnect, 8 DMA |
| cstat_phase | input | 3 | Connection status bus-phase field |
| cstat_sip | input | 1 | Connection status selection-in-progress flag |
| dstat_phase | input | 3 | Transfer status phase counter |
| data_byte | input | 8 | Data register byte |
| link_ack | input | 1 | Target connected pulse |
| link_ack_id | input | 3 | Number of the connected target |
| step_vld | output | 1 | An evaluation step completed; strobes valid |
| phase_nxt | output | 3 | New value for the phase counter |
| cmd_clr | output | 9 | Command bits to clear |
| con_clr | output | 1 | Clear connected status flag |
| sip_set | output | 1 | Set selection-in-progress |
| sip_clr | output | 1 | Clear selection-in-progress |
| sch_set | output | 1 | Set state-change flag |
| tbe_set | output | 1 | Set transmit-buffer-empty |
| tx_vld | output | 1 | Programmed-I/O byte sent |
| tx_byte | output | 8 | Byte sent |
| linked | output | 1 | Internal connected state |
| link_id | output | 3 | Connected target number |

## Verification
The bench checks the data-phase compare against the advanced counter: a command that holds the old counter value must not transfer, so a design that compared before the increment would send a byte it should not send. Select and transfer are set together in one step, and so are disconnect and transfer with selection pending. A design that used the stale selection flag would let the select case through, or block the disconnect case. Disconnect is issued once while linked and once while unlinked, which exposes a state-change flag that ignores the link. A matching transfer with DMA set is checked for silence, which catches a design that clears the command or signals buffer-empty anyway.

// File: rtl/scsi_eng_pkg.sv
`timescale 1ns/1ps
package scsi_eng_pkg;
  localparam int PH_W  = 3;
  localparam int DP_W  = 2;
  localparam int ID_W  = 3;
  localparam int CMD_W = 9;
  // command word layout
  localparam int C_DPH_LO = 0;
  localparam int C_BPH_LO = 2;
  localparam int C_XFER   = 5;
  localparam int C_SEL    = 6;
  localparam int C_DISC   = 7;
  localparam int C_DMA    = 8;

  typedef struct packed {
    logic con_clr;
    logic sip_set;
    logic sip_clr;
    logic sch_set;
    logic tbe_set;
  } stat_strb_t;
endpackage

// File: rtl/scsi_rst_sync.sv
`timescale 1ns/1ps
module scsi_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_sn = sh_q[STAGES-1];
endmodule

// File: rtl/scsi_tick_div.sv
`timescale 1ns/1ps
module scsi_tick_div #(
  parameter int TICK_LOG2 = 14
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  logic [TICK_LOG2-1:0] cnt_q, cnt_n;

  always_comb cnt_n = cnt_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  assign tick_o = &cnt_q;
endmodule

// File: rtl/scsi_cmd_decode.sv
`timescale 1ns/1ps
module scsi_cmd_decode
  import scsi_eng_pkg::*;
(
  input  logic [CMD_W-1:0] cmd_i,
  input  logic [PH_W-1:0]  bph_i,
  input  logic             sip_i,
  input  logic [PH_W-1:0]  dph_i,
  input  logic             linked_i,
  output stat_strb_t       strb_o,
  output logic [CMD_W-1:0] clr_o,
  output logic [PH_W-1:0]  phase_o,
  output logic             xmit_o,
  output logic             unlink_o,
  output logic             wipe_o
);
  logic discon, select, xfer, dma, sip_after, qual;

  always_comb begin
    discon  = cmd_i[C_DISC];
    select  = cmd_i[C_SEL];
    xfer    = cmd_i[C_XFER];
    dma     = cmd_i[C_DMA];
    phase_o = dph_i + 1'b1;
    // order: disconnect, then select, then transfer sees the result
    sip_after = select | (sip_i & ~discon);
    qual = xfer
         && (cmd_i[C_BPH_LO +: PH_W] == bph_i)
         && (cmd_i[C_DPH_LO +: DP_W] == phase_o[DP_W-1:0])
         && !sip_after;
    xmit_o = qual & ~dma;

    strb_o.con_clr = discon;
    strb_o.sip_clr = discon & ~select;
    strb_o.sip_set = select;
    strb_o.sch_set = discon & linked_i;
    strb_o.tbe_set = xmit_o;

    clr_o         = '0;
    clr_o[C_DISC] = discon;
    clr_o[C_SEL]  = select;
    clr_o[C_XFER] = xmit_o;

    unlink_o = discon | select;
    wipe_o   = select;
  end
endmodule

// File: rtl/scsi_link_state.sv
`timescale 1ns/1ps
module scsi_link_state
  import scsi_eng_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_i,
  input  logic [ID_W-1:0] set_id_i,
  input  logic            drop_i,
  input  logic            wipe_i,
  output logic            linked_o,
  output logic [ID_W-1:0] id_o
);
  logic            lk_q, lk_n;
  logic [ID_W-1:0] id_q, id_n;

  always_comb begin
    lk_n = lk_q;
    id_n = id_q;
    if (set_i) begin
      lk_n = 1'b1;
      id_n = set_id_i;
    end
    if (drop_i) lk_n = 1'b0;
    if (wipe_i) id_n = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lk_q <= 1'b0;
      id_q <= '0;
    end else begin
      lk_q <= lk_n;
      id_q <= id_n;
    end
  end

  assign linked_o = lk_q;
  assign id_o     = id_q;
endmodule

// File: rtl/scsi_cmd_engine.sv
`timescale 1ns/1ps
module scsi_cmd_engine
  import scsi_eng_pkg::*;
#(
  parameter int TICK_LOG2 = 14,
  parameter int DATA_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic [CMD_W-1:0]  cmd_word,
  input  logic [PH_W-1:0]   cstat_phase,
  input  logic              cstat_sip,
  input  logic [PH_W-1:0]   dstat_phase,
  input  logic [DATA_W-1:0] data_byte,
  input  logic              link_ack,
  input  logic [ID_W-1:0]   link_ack_id,
  output logic              step_vld,
  output logic [PH_W-1:0]   phase_nxt,
  output logic [CMD_W-1:0]  cmd_clr,
  output logic              con_clr,
  output logic              sip_set,
  output logic              sip_clr,
  output logic              sch_set,
  output logic              tbe_set,
  output logic              tx_vld,
  output logic [DATA_W-1:0] tx_byte,
  output logic              linked,
  output logic [ID_W-1:0]   link_id
);
  logic rst_s;
  logic tick, wr_q, step;
  stat_strb_t       strb, strb_q, strb_n;
  logic [CMD_W-1:0] clr, clr_q, clr_n;
  logic [PH_W-1:0]  phase, phase_q;
  logic [DATA_W-1:0] txb_q;
  logic xmit, unlink, wipe, step_q, tx_q, tx_n;

  scsi_rst_sync #(.STAGES(2)) u_rst (.clk(clk), .rst_n(rst_n), .rst_sn(rst_s));

  scsi_tick_div #(.TICK_LOG2(TICK_LOG2)) u_tick (
    .clk(clk), .rst_n(rst_s), .tick_o(tick));

  scsi_cmd_decode u_dec (
    .cmd_i(cmd_word), .bph_i(cstat_phase), .sip_i(cstat_sip),
    .dph_i(dstat_phase), .linked_i(linked), .strb_o(strb), .clr_o(clr),
    .phase_o(phase), .xmit_o(xmit), .unlink_o(unlink), .wipe_o(wipe));

  scsi_link_state u_link (
    .clk(clk), .rst_n(rst_s), .set_i(link_ack), .set_id_i(link_ack_id),
    .drop_i(step & unlink), .wipe_i(step & wipe),
    .linked_o(linked), .id_o(link_id));

  // write strobe delayed one cycle so the new command word is stable
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) wr_q <= 1'b0;
    else        wr_q <= cmd_wr;
  end

  always_comb begin
    step   = tick | wr_q;
    strb_n = step ? strb : '0;
    clr_n  = step ? clr  : '0;
    tx_n   = step & xmit;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      step_q  <= 1'b0;
      strb_q  <= '0;
      clr_q   <= '0;
      tx_q    <= 1'b0;
      phase_q <= '0;
      txb_q   <= '0;
    end else begin
      step_q <= step;
      strb_q <= strb_n;
      clr_q  <= clr_n;
      tx_q   <= tx_n;
      if (step) phase_q <= phase;
      if (tx_n) txb_q   <= data_byte;
    end
  end

  assign step_vld  = step_q;
  assign phase_nxt = phase_q;
  assign cmd_clr   = clr_q;
  assign con_clr   = strb_q.con_clr;
  assign sip_set   = strb_q.sip_set;
  assign sip_clr   = strb_q.sip_clr;
  assign sch_set   = strb_q.sch_set;
  assign tbe_set   = strb_q.tbe_set;
  assign tx_vld    = tx_q;
  assign tx_byte   = txb_q;

  // R3: no update strobes outside a step
  a_r3_quiet_between_steps: assert property (@(posedge clk) disable iff (!rst_s)
    !step_vld |-> (cmd_clr == '0 && !con_clr && !sip_set && !sip_clr && !sch_set && !tbe_set && !tx_vld));

  // R4: a command write is evaluated two edges later
  a_r4_write_evaluates: assert property (@(posedge clk) disable iff (!rst_s)
    cmd_wr |=> ##1 step_vld);

  // R5: state change only when a link existed before the step
  a_r5_sch_needs_link: assert property (@(posedge clk) disable iff (!rst_s)
    sch_set |-> $past(linked));

  // R6: after a select step nothing is linked
  a_r6_select_unlinks: assert property (@(posedge clk) disable iff (!rst_s)
    sip_set |-> (!linked && link_id == '0));

  // R10: selection flag is never both set and cleared
  a_r10_sip_onehot: assert property (@(posedge clk) disable iff (!rst_s)
    $onehot0({sip_set, sip_clr}));

  // R8: a sent byte comes with buffer-empty and transfer-bit clear
  a_r8_tx_side_effects: assert property (@(posedge clk) disable iff (!rst_s)
    tx_vld |-> (tbe_set && cmd_clr[C_XFER]));

  // R9: a DMA transfer never sends in programmed-I/O mode
  a_r9_dma_silent: assert property (@(posedge clk) disable iff (!rst_s)
    tx_vld |-> !$past(cmd_word[C_DMA]));
endmodule

// File: tb/scsi_cmd_engine_bench.sv
`timescale 1ns/1ps
module scsi_cmd_engine_bench;
  localparam int TL = 5;
  localparam int PERIOD = 1 << TL;

  logic clk = 1'b0;
  logic rst_n;
  logic cmd_wr;
  logic [8:0] cmd_word;
  logic [2:0] cstat_phase, dstat_phase, link_ack_id, phase_nxt, link_id;
  logic cstat_sip, link_ack;
  logic [7:0] data_byte, tx_byte;
  logic step_vld, con_clr, sip_set, sip_clr, sch_set, tbe_set, tx_vld, linked;
  logic [8:0] cmd_clr;

  int n_tests = 0;
  int n_fail  = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  scsi_cmd_engine #(.TICK_LOG2(TL), .DATA_W(8)) u_scsi_cmd_engine (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_word(cmd_word),
    .cstat_phase(cstat_phase), .cstat_sip(cstat_sip), .dstat_phase(dstat_phase),
    .data_byte(data_byte), .link_ack(link_ack), .link_ack_id(link_ack_id),
    .step_vld(step_vld), .phase_nxt(phase_nxt), .cmd_clr(cmd_clr),
    .con_clr(con_clr), .sip_set(sip_set), .sip_clr(sip_clr), .sch_set(sch_set),
    .tbe_set(tbe_set), .tx_vld(tx_vld), .tx_byte(tx_byte),
    .linked(linked), .link_id(link_id));

  function automatic logic [8:0] mk(input int dph, input int bph, input bit x,
                                    input bit s, input bit d, input bit dma);
    mk = {dma, d, s, x, 3'(bph), 2'(dph)};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // wait until a periodic step is seen
  task automatic sync_tick();
    int guard = 0;
    @(negedge clk);
    while (!step_vld && guard < 4 * PERIOD) begin
      @(negedge clk);
      guard++;
    end
    check(step_vld, "R2 sync", int'(step_vld), 1);
  endtask

  // write a command and stop at the negedge where the step is visible
  task automatic do_step(input logic [8:0] c, input logic [2:0] bph, input bit sip,
                         input logic [2:0] dph);
    sync_tick();
    cmd_word = c; cstat_phase = bph; cstat_sip = sip; dstat_phase = dph;
    cmd_wr = 1'b1;
    @(negedge clk);
    cmd_wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic idle_cmd();
    cmd_word = '0; cstat_sip = 1'b0;
  endtask

  task automatic t_reset();
    check(!step_vld && !tx_vld && !con_clr && !sip_set && !sip_clr && !sch_set && !tbe_set,
          "R1 strobes", int'(step_vld), 0);
    check(!linked && link_id == 0, "R1 link", int'(linked), 0);
    check(cmd_clr == 0, "R1 cmd_clr", int'(cmd_clr), 0);
  endtask

  task automatic t_period();
    int n = 0;
    sync_tick();
    do begin @(negedge clk); n++; end while (!step_vld && n < 4 * PERIOD);
    check(n == PERIOD, "R2 period", n, PERIOD);
  endtask

  task automatic t_phase_wrap();
    do_step(mk(0,0,0,0,0,0), 3'd0, 1'b0, 3'd7);
    check(step_vld && phase_nxt == 3'd0, "R3 wrap", int'(phase_nxt), 0);
    check(cmd_clr == 0 && !con_clr && !tbe_set, "R4 empty cmd", int'(cmd_clr), 0);
    @(negedge clk);
    check(!step_vld && cmd_clr == 0, "R3 quiet", int'(step_vld), 0);
    do_step(mk(0,0,0,0,0,0), 3'd0, 1'b0, 3'd4);
    check(phase_nxt == 3'd5, "R3 inc", int'(phase_nxt), 5);
  endtask

  task automatic t_disc_unlinked();
    do_step(mk(0,0,0,0,1,0), 3'd0, 1'b1, 3'd0);
    check(con_clr && sip_clr && !sch_set, "R5 unlinked strobes",
          int'({con_clr, sip_clr, sch_set}), 3'b110);
    check(cmd_clr == 9'h080, "R5 clr", int'(cmd_clr), 'h80);
    idle_cmd();
  endtask

  task automatic t_link();
    sync_tick();
    link_ack = 1'b1; link_ack_id = 3'd5;
    @(negedge clk);
    link_ack = 1'b0;
    check(linked && link_id == 3'd5, "R11 link", int'(link_id), 5);
  endtask

  task automatic t_disc_linked();
    t_link();
    do_step(mk(0,0,0,0,1,0), 3'd0, 1'b0, 3'd0);
    check(sch_set && con_clr, "R5 sch", int'(sch_set), 1);
    check(!linked, "R5 drop", int'(linked), 0);
    idle_cmd();
  endtask

  task automatic t_select();
    t_link();
    do_step(mk(0,0,0,1,0,0), 3'd0, 1'b0, 3'd0);
    check(sip_set && !sip_clr && cmd_clr == 9'h040, "R6 select", int'(cmd_clr), 'h40);
    check(!linked && link_id == 0, "R6 unlink", int'(link_id), 0);
    idle_cmd();
  endtask

  task automatic t_xfer_pio();
    data_byte = 8'hA7;
    do_step(mk(2,3,1,0,0,0), 3'd3, 1'b0, 3'd1);
    check(tx_vld && tx_byte == 8'hA7, "R8 byte", int'(tx_byte), 'hA7);
    check(tbe_set && cmd_clr == 9'h020, "R8 clr", int'(cmd_clr), 'h20);
    @(negedge clk);
    check(!tx_vld, "R8 pulse", int'(tx_vld), 0);
    idle_cmd();
  endtask

  task automatic t_xfer_mismatch();
    do_step(mk(2,4,1,0,0,0), 3'd3, 1'b0, 3'd1);
    check(!tx_vld && !tbe_set && cmd_clr == 0, "R7 bus phase", int'(cmd_clr), 0);
    do_step(mk(1,3,1,0,0,0), 3'd3, 1'b0, 3'd1);
    check(!tx_vld && cmd_clr == 0, "R7 old count", int'(tx_vld), 0);
    do_step(mk(2,3,1,0,0,0), 3'd3, 1'b1, 3'd1);
    check(!tx_vld && !tbe_set, "R7 sip", int'(tx_vld), 0);
    idle_cmd();
  endtask

  task automatic t_xfer_dma();
    do_step(mk(2,3,1,0,0,1), 3'd3, 1'b0, 3'd1);
    check(!tx_vld && !tbe_set && cmd_clr == 0, "R9 dma", int'(cmd_clr), 0);
    idle_cmd();
  endtask

  task automatic t_order();
    data_byte = 8'h3C;
    do_step(mk(2,3,1,1,0,0), 3'd3, 1'b0, 3'd1);
    check(sip_set && !tx_vld && cmd_clr == 9'h040, "R10 select blocks", int'(cmd_clr), 'h40);
    do_step(mk(2,3,1,0,1,0), 3'd3, 1'b1, 3'd1);
    check(tx_vld && tx_byte == 8'h3C && cmd_clr == 9'h0A0, "R10 disc enables",
          int'(cmd_clr), 'hA0);
    idle_cmd();
  endtask

  initial begin
    rst_n = 1'b0; cmd_wr = 1'b0; cmd_word = '0; cstat_phase = '0; cstat_sip = 1'b0;
    dstat_phase = '0; data_byte = '0; link_ack = 1'b0; link_ack_id = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_period();
    t_phase_wrap();
    t_disc_unlinked();
    t_disc_linked();
    t_select();
    t_xfer_pio();
    t_xfer_mismatch();
    t_xfer_dma();
    t_order();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule